// File: doc/BRIEF.md
# Serial Pixel Strip Controller Front End

This block is the software-facing side of a serial pixel-strip driver. It decodes word-aligned register writes from a simple bus and returns read data combinationally for the current address. It holds the frame and bit-timing configuration and drives it on dedicated output ports to a downstream encoder. Pixel words written to the data address are queued in a 32-entry transmit FIFO. The encoder drains that FIFO one word per `enc_pop` pulse.

The FIFO can be refilled in two ways. With DMA turned off, a sticky request flag rises when a running frame has drained the FIFO to the programmed trigger level or below. With DMA turned on, a `dma_req` line stays high while there is enough free space for one burst of trigger-level words. The encoder pulses `enc_done` at the end of a frame. That pulse clears the run bit and raises a finish flag. Both flags are cleared by writing one to them, and they drive a single interrupt line through per-flag enables and a global enable.

Top module: `strip_ctl_front`

## Requirements
- R1: After reset every register reads 0, the FIFO is empty (`enc_valid` 0), and `run`, `dma_req` and `irq` are 0.
- R2: The configuration words read back only their defined fields, and every other bit reads 0. Control (0x00): run bit 0, colour mode 8:6, frame length 28:16. Bit timing (0x04): one-high 26:21, one-low 20:16, zero-high 10:6, zero-low 5:0. Frame gap (0x0C): gap count 28:16, pixel count 9:0. DMA (0x18): enable bit 5, trigger level 4:0. Interrupt enable (0x1C): global bit 5, request bit 1, finish bit 0. The data address 0x14 reads 0.
- R3: Each write to 0x14 appends one word to the FIFO. `enc_word` shows the oldest word while `enc_valid` is 1, and each `enc_pop` advances to the next word in write order. Status (0x20) bits 15:10 give the number of words held.
- R4: A data write while the FIFO holds 32 words is discarded. An `enc_pop` while the FIFO is empty leaves it unchanged.
- R5: Writing control bit 0 as 1 raises `run`. At the clock edge that samples `enc_done`, `run` clears (even if a control write lands at that edge) and status bit 0 (finish) sets.
- R6: While `run` is 1, DMA is disabled and the word count is at or below the trigger level, status bit 1 (request) sets at the next edge. With DMA enabled, it does not set.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it. When a flag's set condition and its clear fall on the same edge, the flag stays set.
- R8: `dma_req` is 1 exactly when DMA is enabled and the free entries (32 minus the count) are at least the trigger level.
- R9: `irq` is the global enable ANDed with the OR of (finish flag AND finish enable) and (request flag AND request enable).
- R10: The colour mode, frame length, four bit-timing counts, gap count and pixel count appear unchanged on their output ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| run | output | 1 | Frame in progress (control bit 0) |
| color_mode | output | 3 | Colour ordering code |
| frame_len | output | 13 | Pixel words in the frame |
| hi1_cyc | output | 6 | High time of a one bit, in clocks |
| lo1_cyc | output | 5 | Low time of a one bit, in clocks |
| hi0_cyc | output | 5 | High time of a zero bit, in clocks |
| lo0_cyc | output | 6 | Low time of a zero bit, in clocks |
| gap_cyc | output | 13 | Latch gap length, in clocks |
| pixel_cnt | output | 10 | Pixel count for the gap logic |
| enc_word | output | 32 | Oldest FIFO word |
| enc_valid | output | 1 | FIFO holds at least one word |
| enc_pop | input | 1 | Encoder takes the oldest word |
| enc_done | input | 1 | Encoder finished the frame |
| dma_req | output | 1 | Refill request to a DMA engine |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that `enc_done` is a single-cycle pulse and that `enc_pop` is only a request, not a guarantee that a word is present. They also assume that the bus presents at most one write per cycle and drives `bus_wr` low during reset. The bench meets these assumptions by driving every input at the falling edge for exactly one clock. It never raises `enc_done` together with a bus write. In the random phase it mixes pushes (including pushes on a full FIFO), pops (including pops on an empty FIFO) and new DMA settings, and it keeps `run` low so that only the FIFO and DMA paths change.

// File: rtl/strip_pkg.sv
package strip_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_TIME  = 8'h04;
  localparam logic [7:0] OFS_GAP   = 8'h0C;
  localparam logic [7:0] OFS_DATA  = 8'h14;
  localparam logic [7:0] OFS_DMA   = 8'h18;
  localparam logic [7:0] OFS_IEN   = 8'h1C;
  localparam logic [7:0] OFS_STAT  = 8'h20;

  // CPU refill condition: running, DMA off, occupancy at or under trigger
  function automatic logic refill_cond(input logic running, input logic dma_on,
                                       input logic [31:0] lvl, input logic [4:0] trig);
    return running && !dma_on && (lvl <= {27'b0, trig});
  endfunction

  // DMA window: free space at least one burst of trig words
  function automatic logic dma_window(input logic dma_on, input logic [4:0] trig,
                                      input logic [31:0] lvl, input logic [31:0] depth);
    return dma_on && ((depth - lvl) >= {27'b0, trig});
  endfunction
endpackage

// File: rtl/strip_fifo.sv
module strip_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push && (level != LW'(DEPTH));
  assign pop_ok  = pop && (level != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end
endmodule

// File: rtl/strip_irq.sv
module strip_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fin_set,
  input  logic       req_set,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  input  logic       gie,
  input  logic       fin_en,
  input  logic       req_en,
  output logic       fin_flag,
  output logic       req_flag,
  output logic       irq
);
  // set beats a same-edge write-one clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_flag <= 1'b0;
      req_flag <= 1'b0;
    end else begin
      fin_flag <= fin_set | (fin_flag & ~(clr_wr & clr_bits[0]));
      req_flag <= req_set | (req_flag & ~(clr_wr & clr_bits[1]));
    end
  end

  assign irq = gie & ((fin_flag & fin_en) | (req_flag & req_en));
endmodule

// File: rtl/strip_ctl_front.sv
module strip_ctl_front
  import strip_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        run,
  output logic [2:0]  color_mode,
  output logic [12:0] frame_len,
  output logic [5:0]  hi1_cyc,
  output logic [4:0]  lo1_cyc,
  output logic [4:0]  hi0_cyc,
  output logic [5:0]  lo0_cyc,
  output logic [12:0] gap_cyc,
  output logic [9:0]  pixel_cnt,
  output logic [31:0] enc_word,
  output logic        enc_valid,
  input  logic        enc_pop,
  input  logic        enc_done,
  output logic        dma_req,
  output logic        irq
);
  logic          dma_en, gie, fin_en, req_en;
  logic [4:0]    trig;
  logic [LW-1:0] lvl;
  logic          fin_flag, req_flag;

  // named internal events for the checker
  logic sel_ctrl, sel_time, sel_gap, sel_data, sel_dma, sel_ien, sel_stat;
  logic push_acc, pop_acc, req_cond_w;

  assign sel_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign sel_time = bus_wr && (bus_addr == OFS_TIME);
  assign sel_gap  = bus_wr && (bus_addr == OFS_GAP);
  assign sel_data = bus_wr && (bus_addr == OFS_DATA);
  assign sel_dma  = bus_wr && (bus_addr == OFS_DMA);
  assign sel_ien  = bus_wr && (bus_addr == OFS_IEN);
  assign sel_stat = bus_wr && (bus_addr == OFS_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      color_mode <= '0;
      frame_len  <= '0;
      hi1_cyc    <= '0;
      lo1_cyc    <= '0;
      hi0_cyc    <= '0;
      lo0_cyc    <= '0;
      gap_cyc    <= '0;
      pixel_cnt  <= '0;
      dma_en     <= 1'b0;
      trig       <= '0;
      gie        <= 1'b0;
      fin_en     <= 1'b0;
      req_en     <= 1'b0;
    end else begin
      if (enc_done)      run <= 1'b0;
      else if (sel_ctrl) run <= bus_wdata[0];
      if (sel_ctrl) begin
        color_mode <= bus_wdata[8:6];
        frame_len  <= bus_wdata[28:16];
      end
      if (sel_time) begin
        hi1_cyc <= bus_wdata[26:21];
        lo1_cyc <= bus_wdata[20:16];
        hi0_cyc <= bus_wdata[10:6];
        lo0_cyc <= bus_wdata[5:0];
      end
      if (sel_gap) begin
        gap_cyc   <= bus_wdata[28:16];
        pixel_cnt <= bus_wdata[9:0];
      end
      if (sel_dma) begin
        dma_en <= bus_wdata[5];
        trig   <= bus_wdata[4:0];
      end
      if (sel_ien) begin
        gie    <= bus_wdata[5];
        req_en <= bus_wdata[1];
        fin_en <= bus_wdata[0];
      end
    end
  end

  strip_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (sel_data),
    .pop     (enc_pop),
    .din     (bus_wdata),
    .dout    (enc_word),
    .level   (lvl),
    .push_ok (push_acc),
    .pop_ok  (pop_acc)
  );

  assign enc_valid  = (lvl != '0);
  assign req_cond_w = refill_cond(run, dma_en, 32'(lvl), trig);
  assign dma_req    = dma_window(dma_en, trig, 32'(lvl), 32'(DEPTH));

  strip_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin_set  (enc_done),
    .req_set  (req_cond_w),
    .clr_wr   (sel_stat),
    .clr_bits (bus_wdata[1:0]),
    .gie      (gie),
    .fin_en   (fin_en),
    .req_en   (req_en),
    .fin_flag (fin_flag),
    .req_flag (req_flag),
    .irq      (irq)
  );

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {3'b0, frame_len, 7'b0, color_mode, 5'b0, run};
      OFS_TIME: bus_rdata = {5'b0, hi1_cyc, lo1_cyc, 5'b0, hi0_cyc, lo0_cyc};
      OFS_GAP:  bus_rdata = {3'b0, gap_cyc, 6'b0, pixel_cnt};
      OFS_DMA:  bus_rdata = {26'b0, dma_en, trig};
      OFS_IEN:  bus_rdata = {26'b0, gie, 3'b0, req_en, fin_en};
      OFS_STAT: bus_rdata = {16'b0, 6'(lvl), 8'b0, req_flag, fin_flag};
      default:  bus_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/strip_ctl_front_chk.sv
module strip_ctl_front_chk #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          dma_en,
  input logic          gie,
  input logic [LW-1:0] lvl,
  input logic          push_acc,
  input logic          pop_acc,
  input logic          wr_data,
  input logic          enc_pop,
  input logic          enc_done,
  input logic          fin_flag,
  input logic          req_flag,
  input logic          req_cond_w,
  input logic          dma_req,
  input logic          irq
);
  a_r3_level_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl == LW'($past(lvl) + LW'($past(push_acc)) - LW'($past(pop_acc))));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));

  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == LW'(DEPTH) && wr_data && !enc_pop) |=> lvl == LW'(DEPTH));

  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0 && enc_pop && !wr_data) |=> lvl == '0);

  a_r5_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |=> (!run && fin_flag));

  a_r6_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    req_cond_w |=> req_flag);

  a_r8_dma_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);
endmodule

bind strip_ctl_front strip_ctl_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .dma_en     (dma_en),
  .gie        (gie),
  .lvl        (lvl),
  .push_acc   (push_acc),
  .pop_acc    (pop_acc),
  .wr_data    (sel_data),
  .enc_pop    (enc_pop),
  .enc_done   (enc_done),
  .fin_flag   (fin_flag),
  .req_flag   (req_flag),
  .req_cond_w (req_cond_w),
  .dma_req    (dma_req),
  .irq        (irq)
);

// File: tb/strip_ctl_front_bench.sv
module strip_ctl_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        run, enc_valid, dma_req, irq;
  logic [2:0]  color_mode;
  logic [12:0] frame_len, gap_cyc;
  logic [5:0]  hi1_cyc, lo0_cyc;
  logic [4:0]  lo1_cyc, hi0_cyc;
  logic [9:0]  pixel_cnt;
  logic [31:0] enc_word;
  logic        enc_pop = 1'b0;
  logic        enc_done = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] q[$];
  logic        m_dma_en = 1'b0;
  logic [4:0]  m_trig = 5'd0;

  always #2 clk = ~clk;

  strip_ctl_front u_strip_ctl_front (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run(run),
    .color_mode(color_mode), .frame_len(frame_len), .hi1_cyc(hi1_cyc),
    .lo1_cyc(lo1_cyc), .hi0_cyc(hi0_cyc), .lo0_cyc(lo0_cyc),
    .gap_cyc(gap_cyc), .pixel_cnt(pixel_cnt), .enc_word(enc_word),
    .enc_valid(enc_valid), .enc_pop(enc_pop), .enc_done(enc_done),
    .dma_req(dma_req), .irq(irq)
  );

  function automatic logic exp_dma(input logic en, input logic [4:0] t, input int lvl);
    return en && (lvl + int'(t) <= 32);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    wr(8'h14, d);
    if (q.size() < 32) q.push_back(d);
  endtask

  task automatic pop_chk(input string tag);
    if (q.size() > 0) begin
      chk({tag, " valid"}, {31'b0, enc_valid}, 32'd1);
      chk({tag, " word"}, enc_word, q[0]);
      void'(q.pop_front());
    end
    @(negedge clk); enc_pop = 1'b1;
    @(negedge clk); enc_pop = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); enc_done = 1'b1;
    @(negedge clk); enc_done = 1'b0;
  endtask

  task automatic chk_level(input string tag, input logic [1:0] flags);
    logic [31:0] v;
    rd(8'h20, v);
    chk(tag, v, (32'(q.size()) << 10) | {30'b0, flags});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got hung exp finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, tw, gw, cw;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    foreach (v[i]) begin end
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 time", v, 0);
    rd(8'h0C, v); chk("R1 gap", v, 0);
    rd(8'h18, v); chk("R1 dma", v, 0);
    rd(8'h1C, v); chk("R1 ien", v, 0);
    rd(8'h20, v); chk("R1 stat", v, 0);
    chk("R1 outs", {28'b0, run, enc_valid, dma_req, irq}, 0);

    // R2 / R10 field placement
    tw = (32'h2A << 21) | (32'h13 << 16) | (32'h0B << 6) | 32'h25;
    wr(8'h04, tw | 32'hF800F800);
    rd(8'h04, v); chk("R2 time", v, tw);
    chk("R10 hi1", {26'b0, hi1_cyc}, 32'h2A);
    chk("R10 lo1", {27'b0, lo1_cyc}, 32'h13);
    chk("R10 hi0", {27'b0, hi0_cyc}, 32'h0B);
    chk("R10 lo0", {26'b0, lo0_cyc}, 32'h25);
    gw = (32'h1ABC << 16) | 32'h2F5;
    wr(8'h0C, gw | 32'hE000FC00);
    rd(8'h0C, v); chk("R2 gap", v, gw);
    chk("R10 gap", {19'b0, gap_cyc}, 32'h1ABC);
    chk("R10 pix", {22'b0, pixel_cnt}, 32'h2F5);
    cw = (32'h0123 << 16) | (32'h5 << 6);
    wr(8'h00, cw | 32'hE000FE3E);
    rd(8'h00, v); chk("R2 ctrl", v, cw);
    chk("R10 mode", {29'b0, color_mode}, 32'h5);
    chk("R10 len", {19'b0, frame_len}, 32'h0123);
    wr(8'h18, 32'hFFFFFFC0 | 32'h31);
    rd(8'h18, v); chk("R2 dma", v, 32'h31);
    wr(8'h1C, 32'hFFFFFFFF);
    rd(8'h1C, v); chk("R2 ien", v, 32'h23);
    chk("R9 no flags", {31'b0, irq}, 0);
    wr(8'h1C, 0);
    rd(8'h14, v); chk("R2 data reads 0", v, 0);

    // R5 start/finish, R8 at empty, R6 suppressed by DMA, R7, R9
    wr(8'h18, 32'h30); m_dma_en = 1'b1; m_trig = 5'd16;
    chk("R8 empty dma", {31'b0, dma_req}, 32'd1);
    wr(8'h00, cw | 32'h1);
    chk("R5 run up", {31'b0, run}, 32'd1);
    rd(8'h00, v); chk("R5 ctrl bit0", v, cw | 32'h1);
    tick(); tick();
    rd(8'h20, v); chk("R6 no req with dma", v, 0);
    done_pulse();
    chk("R5 run cleared", {31'b0, run}, 0);
    rd(8'h00, v); chk("R5 ctrl bit0 cleared", v, cw);
    rd(8'h20, v); chk("R5 finish flag", v, 32'h1);
    wr(8'h20, 0);
    rd(8'h20, v); chk("R7 write zero keeps", v, 32'h1);
    wr(8'h1C, 32'h01); chk("R9 no gie", {31'b0, irq}, 0);
    wr(8'h1C, 32'h21); chk("R9 finish irq", {31'b0, irq}, 32'd1);
    wr(8'h1C, 32'h22); chk("R9 finish masked", {31'b0, irq}, 0);
    wr(8'h20, 32'h1);
    rd(8'h20, v); chk("R7 clear finish", v, 0);

    // R8 threshold, R3 level
    for (int i = 0; i < 16; i++) push($urandom);
    chk_level("R3 level 16", 2'b00);
    chk("R8 free16 trig16", {31'b0, dma_req}, 32'd1);
    push($urandom);
    chk("R8 free15 trig16", {31'b0, dma_req}, 0);

    // R6 CPU request, R7 set-wins, R9
    wr(8'h18, 32'h0F); m_dma_en = 1'b0; m_trig = 5'd15;
    chk("R8 dma off", {31'b0, dma_req}, 0);
    wr(8'h00, 32'h1);
    tick();
    chk_level("R6 above trig", 2'b00);
    pop_chk("R3 pop");
    tick();
    chk_level("R6 at 16", 2'b00);
    pop_chk("R3 pop");
    tick();
    chk_level("R6 at trig sets", 2'b10);
    chk("R9 req irq", {31'b0, irq}, 32'd1);
    wr(8'h20, 32'h2);
    chk_level("R7 set wins", 2'b10);
    done_pulse();
    tick();
    wr(8'h20, 32'h3);
    chk_level("R7 clear both", 2'b00);
    chk("R9 irq low", {31'b0, irq}, 0);
    wr(8'h1C, 0);

    // R4 full drop and empty pop
    while (q.size() < 32) push($urandom);
    push(32'hDEADBEEF);
    chk_level("R4 full holds 32", 2'b00);
    while (q.size() > 0) pop_chk("R4 order");
    pop_chk("R4 empty pop");
    chk_level("R4 empty stays", 2'b00);
    chk("R4 valid low", {31'b0, enc_valid}, 0);

    // random FIFO / DMA traffic: R3 R4 R8
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 5);
      if (op <= 1) push($urandom);
      else if (op <= 3) pop_chk("R3 rnd");
      else begin
        m_dma_en = 1'($urandom);
        m_trig = 5'($urandom);
        wr(8'h18, {26'b0, m_dma_en, m_trig});
      end
      chk_level("R3 rnd level", 2'b00);
      chk("R8 rnd dma", {31'b0, dma_req}, {31'b0, exp_dma(m_dma_en, m_trig, q.size())});
      chk("R3 rnd valid", {31'b0, enc_valid}, {31'b0, q.size() != 0});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule